// File: doc/BRIEF.md
# PCI Subtractive Decode Claim Unit

This block sits on a 32-bit PCI bus as a default target. It does not decode an address range of its own. It watches each new transaction and claims any transaction that no other agent has accepted. On the clock edge that starts a transaction, it captures the address and the bus command. It then gives the positive-decode agents a fixed window of three clock edges to assert DEVSEL#. If none of them responds, the block drives DEVSEL# itself on the fourth edge.

The block passes each accepted transaction to a downstream legacy-bus engine. It does this with a single-cycle handoff pulse that carries the captured address, command and first-phase byte enables. The engine acknowledges the handoff with a done pulse. Only one handoff may be pending at any time.

Some commands are never claimed: configuration reads and writes, interrupt acknowledge and special cycles. A control register holds one decode-off bit that switches the whole function off. DEVSEL# appears as separate value and enable outputs, so the pad logic outside the block builds the tri-state driver.

Top module: `pci_subdec_claim`

## Requirements
- R1: After reset, devsel_oe_o is 0, devsel_n_o is 1, hand_valid_o is 0 and ctrl_rdata_o reads 0, so decode is enabled.
- R2: Bit 10 of the control register is the decode-off flag. A write with ctrl_we_i high stores bit 10 of ctrl_wdata_i. Reads return that flag at bit 10 and zero in every other bit.
- R3: Transactions with command 4'h0 (interrupt acknowledge), 4'h1 (special cycle), 4'hA (configuration read) or 4'hB (configuration write) are never claimed. For these, DEVSEL# is never driven and no handoff occurs.
- R4: The address on ad_i and the command on cbe_n_i are captured on edge E0. E0 is the edge at which frame_n_i is first sampled low while the bus is idle. The byte enables on cbe_n_i are captured on the next edge, E1.
- R5: If devsel_n_in is sampled low at E1, E2 or E3, the block ignores the transaction. It drives nothing and makes no handoff until the bus is sampled idle, which means frame_n_i and irdy_n_i are both high.
- R6: If no agent responds in that window, devsel_oe_o rises and devsel_n_o falls after E4, and not earlier.
- R7: hand_valid_o is high for exactly the one cycle after the claim edge E4. During that cycle hand_addr_o, hand_cmd_o and hand_be_n_o hold the captured values.
- R8: A claimed DEVSEL# stays low until frame_n_i and irdy_n_i are both sampled high. It is then driven high for one cycle, after which the enable is released. This also applies when FRAME# is deasserted early, while IRDY# is still low.
- R9: While the decode-off flag is 1, the block never enables DEVSEL# and never raises hand_valid_o.
- R10: After a handoff, no further transaction is claimed until hand_done_i has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frame_n_i | input | 1 | Sampled FRAME# |
| irdy_n_i | input | 1 | Sampled IRDY# |
| ad_i | input | 32 | Sampled address/data bus |
| cbe_n_i | input | 4 | Sampled command / byte-enable nibble |
| devsel_n_in | input | 1 | DEVSEL# as driven by the other agents |
| devsel_n_o | output | 1 | DEVSEL# value driven by this block |
| devsel_oe_o | output | 1 | Output enable for DEVSEL# |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control register write data |
| ctrl_rdata_o | output | 32 | Control register read data |
| hand_valid_o | output | 1 | One-cycle handoff pulse |
| hand_addr_o | output | 32 | Captured address |
| hand_cmd_o | output | 4 | Captured bus command |
| hand_be_n_o | output | 4 | Captured first-phase byte enables |
| hand_done_i | input | 1 | Downstream engine finished the handoff |

## Verification
The hardest behaviour to reach from the ports is a late claim by another agent, one that arrives on the last edge of the window, E3. If the window were one edge short, the block would already be driving DEVSEL# against that agent. The stimulus task places the other agent's DEVSEL# at a chosen edge, E1, E2 or E3, relative to the address phase. It checks at every edge of the window that the enable stays low, so an off-by-one in either direction is caught. A second sequence withholds the done pulse after a claim and then sends another transaction. This proves the pending-handoff lock-out before the lock is cleared.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
    localparam int SDC_AD_W  = 32;
    localparam int SDC_CMD_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIN,
        ST_CLAIM,
        ST_TURN,
        ST_WAIT
    } sdc_state_e;

    typedef struct packed {
        logic [SDC_AD_W-1:0]  addr;
        logic [SDC_CMD_W-1:0] cmd;
        logic [SDC_CMD_W-1:0] be_n;
    } sdc_xfer_t;
endpackage

// File: rtl/sdc_ctrl_reg.sv
`timescale 1ns/1ps
module sdc_ctrl_reg #(
    parameter int CTRL_W  = 32,
    parameter int OFF_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] rdata_o,
    output logic              off_o
);
    logic off_d, off_q;

    always_comb begin
        off_d = off_q;
        if (we_i) off_d = wdata_i[OFF_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= off_d;
    end

    always_comb begin
        rdata_o          = '0;
        rdata_o[OFF_BIT] = off_q;
    end

    assign off_o = off_q;
endmodule

// File: rtl/sdc_cmd_filter.sv
`timescale 1ns/1ps
module sdc_cmd_filter #(
    parameter int          CMD_W = 4,
    parameter logic [15:0] EXCL  = 16'h0C03
) (
    input  logic [CMD_W-1:0] cmd_i,
    output logic             ok_o
);
    localparam int NCMD = 1 << CMD_W;
    logic [NCMD-1:0] allow;

    for (genvar g = 0; g < NCMD; g++) begin : g_cmd
        assign allow[g] = !EXCL[g];
    end

    assign ok_o = allow[cmd_i];
endmodule

// File: rtl/sdc_handoff_track.sv
`timescale 1ns/1ps
module sdc_handoff_track (
    input  logic clk,
    input  logic rst_n,
    input  logic claim_i,
    input  logic done_i,
    output logic busy_o
);
    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (done_i)  busy_d = 1'b0;
        if (claim_i) busy_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/sdc_claim_fsm.sv
`timescale 1ns/1ps
module sdc_claim_fsm
    import sdc_pkg::*;
#(
    parameter int WINDOW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n_i,
    input  logic                 irdy_n_i,
    input  logic [SDC_AD_W-1:0]  ad_i,
    input  logic [SDC_CMD_W-1:0] cbe_n_i,
    input  logic                 devsel_n_in,
    input  logic                 cmd_ok_i,
    input  logic                 off_i,
    input  logic                 busy_i,
    output logic                 claim_now_o,
    output logic                 devsel_n_o,
    output logic                 devsel_oe_o,
    output logic                 hand_valid_o,
    output sdc_xfer_t            xfer_o
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW);

    typedef struct packed {
        sdc_state_e      st;
        logic [CNT_W-1:0] cnt;
        sdc_xfer_t       xf;
        logic            dv_n;
        logic            dv_oe;
        logic            hv;
    } fsm_t;

    fsm_t d, q;
    logic bus_idle;

    assign bus_idle = frame_n_i && irdy_n_i;

    always_comb begin
        d    = q;
        d.hv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                d.dv_oe = 1'b0;
                d.dv_n  = 1'b1;
                if (!frame_n_i) begin
                    d.xf.addr = ad_i;
                    d.xf.cmd  = cbe_n_i;
                    d.cnt     = '0;
                    d.st      = (cmd_ok_i && !off_i) ? ST_WIN : ST_WAIT;
                end
            end
            ST_WIN: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == '0) d.xf.be_n = cbe_n_i;
                if (q.cnt < LAST) begin
                    if (!devsel_n_in) d.st = ST_WAIT;
                end else if (!off_i && !busy_i) begin
                    d.st    = ST_CLAIM;
                    d.dv_oe = 1'b1;
                    d.dv_n  = 1'b0;
                    d.hv    = 1'b1;
                end else begin
                    d.st = ST_WAIT;
                end
            end
            ST_CLAIM: begin
                if (bus_idle) begin
                    d.st   = ST_TURN;
                    d.dv_n = 1'b1;
                end
            end
            ST_TURN: begin
                d.st    = ST_IDLE;
                d.dv_oe = 1'b0;
                d.dv_n  = 1'b1;
            end
            ST_WAIT: begin
                if (bus_idle) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.cnt   <= '0;
            q.xf    <= '0;
            q.dv_n  <= 1'b1;
            q.dv_oe <= 1'b0;
            q.hv    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign claim_now_o  = d.hv;
    assign devsel_n_o   = q.dv_n;
    assign devsel_oe_o  = q.dv_oe;
    assign hand_valid_o = q.hv;
    assign xfer_o       = q.xf;
endmodule

// File: rtl/pci_subdec_claim.sv
`timescale 1ns/1ps
module pci_subdec_claim
    import sdc_pkg::*;
#(
    parameter int          CTRL_W  = 32,
    parameter int          OFF_BIT = 10,
    parameter int          WINDOW  = 3,
    parameter logic [15:0] EXCL    = 16'h0C03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n_i,
    input  logic                 irdy_n_i,
    input  logic [SDC_AD_W-1:0]  ad_i,
    input  logic [SDC_CMD_W-1:0] cbe_n_i,
    input  logic                 devsel_n_in,
    output logic                 devsel_n_o,
    output logic                 devsel_oe_o,
    input  logic                 ctrl_we_i,
    input  logic [CTRL_W-1:0]    ctrl_wdata_i,
    output logic [CTRL_W-1:0]    ctrl_rdata_o,
    output logic                 hand_valid_o,
    output logic [SDC_AD_W-1:0]  hand_addr_o,
    output logic [SDC_CMD_W-1:0] hand_cmd_o,
    output logic [SDC_CMD_W-1:0] hand_be_n_o,
    input  logic                 hand_done_i
);
    logic      off, cmd_ok, busy, claim_now;
    sdc_xfer_t xf;

    sdc_ctrl_reg #(.CTRL_W(CTRL_W), .OFF_BIT(OFF_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we_i(ctrl_we_i), .wdata_i(ctrl_wdata_i),
        .rdata_o(ctrl_rdata_o), .off_o(off)
    );

    sdc_cmd_filter #(.CMD_W(SDC_CMD_W), .EXCL(EXCL)) u_filt (
        .cmd_i(cbe_n_i), .ok_o(cmd_ok)
    );

    sdc_handoff_track u_track (
        .clk(clk), .rst_n(rst_n), .claim_i(claim_now), .done_i(hand_done_i),
        .busy_o(busy)
    );

    sdc_claim_fsm #(.WINDOW(WINDOW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
        .ad_i(ad_i), .cbe_n_i(cbe_n_i), .devsel_n_in(devsel_n_in),
        .cmd_ok_i(cmd_ok), .off_i(off), .busy_i(busy), .claim_now_o(claim_now),
        .devsel_n_o(devsel_n_o), .devsel_oe_o(devsel_oe_o),
        .hand_valid_o(hand_valid_o), .xfer_o(xf)
    );

    assign hand_addr_o = xf.addr;
    assign hand_cmd_o  = xf.cmd;
    assign hand_be_n_o = xf.be_n;
endmodule

// File: rtl/sdc_checker.sv
`timescale 1ns/1ps
module sdc_checker #(
    parameter int CTRL_W  = 32,
    parameter int OFF_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              devsel_n_o,
    input logic              devsel_oe_o,
    input logic              hand_valid_o,
    input logic [3:0]        hand_cmd_o,
    input logic [CTRL_W-1:0] ctrl_rdata_o
);
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid_o |=> !hand_valid_o);

    assert_strobe_with_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid_o |-> (devsel_oe_o && !devsel_n_o && $rose(devsel_oe_o)));

    assert_no_excluded_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid_o |-> !(hand_cmd_o == 4'h0 || hand_cmd_o == 4'h1 ||
                           hand_cmd_o == 4'hA || hand_cmd_o == 4'hB));

    assert_off_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_oe_o) |-> !$past(ctrl_rdata_o[OFF_BIT]));

    assert_release_after_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_oe_o) |-> $past(devsel_n_o));

    assert_high_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe_o && devsel_n_o) |=> !devsel_oe_o);
endmodule

bind pci_subdec_claim sdc_checker #(.CTRL_W(CTRL_W), .OFF_BIT(OFF_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .devsel_n_o(devsel_n_o), .devsel_oe_o(devsel_oe_o),
    .hand_valid_o(hand_valid_o), .hand_cmd_o(hand_cmd_o), .ctrl_rdata_o(ctrl_rdata_o)
);

// File: tb/sim_pci_subdec_claim.sv
`timescale 1ns/1ps
module sim_pci_subdec_claim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, dev_in = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = 4'hF;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        hand_done = 1'b0;
    logic        devsel_n_o, devsel_oe_o, hand_valid_o;
    logic [31:0] ctrl_rdata_o, hand_addr_o;
    logic [3:0]  hand_cmd_o, hand_be_n_o;

    int checks = 0, fails = 0, strobes = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    pci_subdec_claim u0 (
        .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
        .ad_i(ad), .cbe_n_i(cbe), .devsel_n_in(dev_in),
        .devsel_n_o(devsel_n_o), .devsel_oe_o(devsel_oe_o),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata_o),
        .hand_valid_o(hand_valid_o), .hand_addr_o(hand_addr_o),
        .hand_cmd_o(hand_cmd_o), .hand_be_n_o(hand_be_n_o), .hand_done_i(hand_done)
    );

    always @(negedge clk) if (hand_valid_o) strobes++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [31:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input logic [3:0] be,
                           input int other_edge, input bit exp_claim, input int hold,
                           input bit early, input bit ack, input string tag);
        int s0;
        s0 = strobes;
        @(negedge clk); frame_n = 1'b0; ad = addr; cbe = cmd; irdy_n = 1'b1;
        @(negedge clk); cbe = be; irdy_n = 1'b0; ad = 32'h5A5A_A5A5;
        if (early) frame_n = 1'b1;
        if (other_edge == 1) dev_in = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk(devsel_oe_o == 1'b0, {tag, " R6 no drive inside window"}, devsel_oe_o, 0);
            if (other_edge == k + 1) dev_in = 1'b0;
        end
        @(negedge clk);
        if (exp_claim) begin
            chk(devsel_oe_o && !devsel_n_o, {tag, " R6 claim after E4"}, {devsel_oe_o, devsel_n_o}, 2'b10);
            chk(hand_valid_o == 1'b1, {tag, " R7 strobe"}, hand_valid_o, 1);
            chk(hand_addr_o == addr, {tag, " R4 addr"}, hand_addr_o, addr);
            chk(hand_cmd_o == cmd, {tag, " R4 cmd"}, hand_cmd_o, cmd);
            chk(hand_be_n_o == be, {tag, " R4 be"}, hand_be_n_o, be);
        end else begin
            chk(!devsel_oe_o && !hand_valid_o, {tag, " no claim"}, {devsel_oe_o, hand_valid_o}, 0);
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(hand_valid_o == 1'b0, {tag, " R7 single pulse"}, hand_valid_o, 0);
            if (exp_claim)
                chk(devsel_oe_o && !devsel_n_o, {tag, " R8 hold low"}, {devsel_oe_o, devsel_n_o}, 2'b10);
            else
                chk(!devsel_oe_o, {tag, " no drive"}, devsel_oe_o, 0);
        end
        frame_n = 1'b1; irdy_n = 1'b1; dev_in = 1'b1;
        @(negedge clk);
        if (exp_claim)
            chk(devsel_oe_o && devsel_n_o, {tag, " R8 high turnaround"}, {devsel_oe_o, devsel_n_o}, 2'b11);
        else
            chk(!devsel_oe_o, {tag, " no drive at end"}, devsel_oe_o, 0);
        @(negedge clk);
        chk(!devsel_oe_o, {tag, " R8 released"}, devsel_oe_o, 0);
        if (ack) begin
            hand_done = 1'b1;
            @(negedge clk); hand_done = 1'b0;
        end
        chk((strobes - s0) == (exp_claim ? 1 : 0), {tag, " strobe count"}, strobes - s0, exp_claim ? 1 : 0);
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        chk(!devsel_oe_o && devsel_n_o, "R1 devsel reset", {devsel_oe_o, devsel_n_o}, 2'b01);
        chk(!hand_valid_o, "R1 strobe reset", hand_valid_o, 0);
        chk(ctrl_rdata_o == 0, "R1 ctrl reset", ctrl_rdata_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_basic;
        run_txn(4'h6, 32'h0000_0378, 4'b1110, 0, 1, 3, 0, 1, "R6 memread");
        run_txn(4'h3, 32'h0000_02F8, 4'b0000, 0, 1, 1, 1, 1, "R8 early frame iowrite");
        run_txn(4'h2, 32'hFFFF_FFFC, 4'b0101, 0, 1, 2, 0, 1, "R4 ioread");
    endtask

    task automatic test_other_claims;
        run_txn(4'h6, 32'h1000_0000, 4'h0, 1, 0, 2, 0, 0, "R5 fast");
        run_txn(4'h6, 32'h1000_0004, 4'h0, 2, 0, 2, 0, 0, "R5 medium");
        run_txn(4'h7, 32'h1000_0008, 4'h0, 3, 0, 2, 0, 0, "R5 slow");
    endtask

    task automatic test_excluded;
        run_txn(4'h0, 32'h0, 4'h0, 0, 0, 1, 0, 0, "R3 intack");
        run_txn(4'h1, 32'h0, 4'h0, 0, 0, 1, 0, 0, "R3 special");
        run_txn(4'hA, 32'h8000_0000, 4'h0, 0, 0, 1, 0, 0, "R3 cfgrd");
        run_txn(4'hB, 32'h8000_0004, 4'h0, 0, 0, 1, 0, 0, "R3 cfgwr");
    endtask

    task automatic test_disable;
        ctrl_write(32'h0000_0400);
        chk(ctrl_rdata_o == 32'h400, "R2 readback off", ctrl_rdata_o, 32'h400);
        run_txn(4'h6, 32'h2000_0000, 4'h3, 0, 0, 2, 0, 0, "R9 off");
        ctrl_write(32'hFFFF_FBFF);
        chk(ctrl_rdata_o == 32'h0, "R2 other bits zero", ctrl_rdata_o, 0);
        ctrl_write(32'hFFFF_FFFF);
        chk(ctrl_rdata_o == 32'h400, "R2 only bit10", ctrl_rdata_o, 32'h400);
        ctrl_write(32'h0);
        run_txn(4'h6, 32'h2000_0010, 4'h3, 0, 1, 1, 0, 1, "R9 re-enabled");
    endtask

    task automatic test_outstanding;
        run_txn(4'h6, 32'h3000_0000, 4'h0, 0, 1, 1, 0, 0, "R10 first");
        run_txn(4'h6, 32'h3000_0004, 4'h0, 0, 0, 1, 0, 0, "R10 blocked");
        @(negedge clk); hand_done = 1'b1;
        @(negedge clk); hand_done = 1'b0;
        run_txn(4'h6, 32'h3000_0008, 4'hC, 0, 1, 1, 0, 1, "R10 after done");
    endtask

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_basic();
        test_other_claims();
        test_excluded();
        test_disable();
        test_outstanding();
        repeat (2) @(negedge clk);
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule